// File: doc/BRIEF.md
# Three-Level Programmable Address Decoder

This block turns a 16-bit processor address into fourteen shared, active-low card-select lines for a backplane. Software or boot logic programs it through a small synchronous configuration port. Expansion cards then use one select line each and need no decode logic of their own.

Decoding is nested. At the coarse level the address space is cut into sixteen 4 KB blocks, chosen by the top nibble. One block can be nominated for finer decoding. Inside that block, sixteen 256-byte pages are chosen by the next nibble. One of those pages can in turn be nominated, and inside it sixteen 16-byte segments are chosen by bits [7:4]. Every unit at every level has its own routing entry. An entry holds an enable and the number of the select line it drives, and any number of units may share a line.

The select lines follow the address combinationally and are asserted only while the address-valid input is high.

Top module: `addr_map_decoder`

## Requirements
- R1: After reset every routing entry and both source enables are cleared, so all `map_n` lines stay high for any address, even with `addr_valid` high.
- R2: While `addr_valid` is low, all `map_n` lines are high, whatever the configuration.
- R3: For an address outside the nominated block, the block entry picked by `addr[15:12]` decides the output. If that entry is enabled with index k < 14, `map_n[k]` is low and all other lines are high.
- R4: Several units may name the same line, and that line is low for an address in any of them.
- R5: When the page source is enabled and `addr[15:12]` equals its block number, the block entry is ignored and the page entry picked by `addr[11:8]` decides the output.
- R6: When the segment source is also enabled and `addr[11:8]` equals its page number inside the nominated block, the page entry is ignored and the segment entry picked by `addr[7:4]` decides the output.
- R7: A disabled entry, or an enabled entry whose index is 14 or 15, drives no line.
- R8: Configuration encoding. `cfg_addr[5:4]` selects the target: 0 is the block table, 1 the page table and 2 the segment table, each indexed by `cfg_addr[3:0]`. Value 3 selects a source register: `cfg_addr[0]`=0 is the page source (a block number) and 1 is the segment source (a page number). `cfg_wdata[4]` is the enable and `cfg_wdata[3:0]` is the index or number. A write with `cfg_we` high is applied at the next rising clock edge and not before.
- R9: At most one `map_n` line is low at any time.
- R10: Clearing the page source enable gives the nominated block back to its own block-level entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| addr_valid | input | 1 | Address qualifier; selects only while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration target (see R8) |
| cfg_wdata | input | 5 | Enable bit and 4-bit index (see R8) |
| map_n | output | 14 | Active-low select lines |

## Verification
The bench checks how the levels override each other. An address in the nominated block, but outside the nominated page, must use the page entry even though the block entry is also programmed. A decoder that ORed the levels together instead would drive two lines at once. Indexes 14 and 15 and disabled entries must stay silent; a decoder that wrapped or truncated the index would assert some other line. The bench also checks that a write does not show before the clock edge, and that turning the page source off hands the block back to its coarse entry. A full sweep of the 65536 addresses against the bench's own model then catches off-by-one errors in which address bits each level uses.

// File: rtl/amd_pkg.sv
package amd_pkg;
    localparam int SEL_W  = 4;               // address bits per level
    localparam int UNITS  = 1 << SEL_W;      // units per level
    localparam int IDX_W  = 4;               // select line index width
    localparam int CFG_AW = SEL_W + 2;       // config address width
    localparam int CFG_DW = IDX_W + 1;       // config data width
    localparam int LEVELS = 3;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
    } route_t;

    typedef struct packed {
        route_t [UNITS-1:0] blk;
        route_t [UNITS-1:0] pg;
        route_t [UNITS-1:0] seg;
        route_t             pg_src;
        route_t             seg_src;
    } cfg_t;
endpackage

// File: rtl/amd_cfg_regs.sv
module amd_cfg_regs
    import amd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] waddr,
    input  logic [CFG_DW-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;
    route_t wr_val;
    logic [SEL_W-1:0] slot;

    always_comb begin
        cfg_d  = cfg_q;
        wr_val = route_t'(wdata);
        slot   = waddr[SEL_W-1:0];
        if (we) begin
            unique case (waddr[CFG_AW-1 -: 2])
                2'd0: cfg_d.blk[slot] = wr_val;
                2'd1: cfg_d.pg[slot]  = wr_val;
                2'd2: cfg_d.seg[slot] = wr_val;
                default: begin
                    if (waddr[0]) cfg_d.seg_src = wr_val;
                    else          cfg_d.pg_src  = wr_val;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R8: settings only move on a write
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/amd_route_dec.sv
module amd_route_dec
    import amd_pkg::*;
#(
    parameter int NUM_MAP = 14
) (
    input  route_t             r,
    input  logic               active,
    output logic [NUM_MAP-1:0] hit
);
    for (genvar g = 0; g < NUM_MAP; g++) begin : g_line
        assign hit[g] = active & r.en & (r.idx == IDX_W'(g));
    end
endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
    import amd_pkg::*;
#(
    parameter int NUM_MAP = 14,
    parameter int ADDR_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               addr_valid,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    output logic [NUM_MAP-1:0] map_n
);
    localparam int BLK_LSB = ADDR_W - SEL_W;
    localparam int PG_LSB  = BLK_LSB - SEL_W;
    localparam int SEG_LSB = PG_LSB - SEL_W;

    cfg_t cfg;
    logic [SEL_W-1:0] blk_f, pg_f, seg_f;
    logic in_pg, in_seg;
    route_t [LEVELS-1:0] lvl_route;
    logic   [LEVELS-1:0] lvl_act;
    logic   [LEVELS-1:0][NUM_MAP-1:0] lvl_hit;
    logic   [NUM_MAP-1:0] any_hit;

    amd_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    always_comb begin
        blk_f  = addr[BLK_LSB +: SEL_W];
        pg_f   = addr[PG_LSB  +: SEL_W];
        seg_f  = addr[SEG_LSB +: SEL_W];
        in_pg  = cfg.pg_src.en && (blk_f == cfg.pg_src.idx);
        in_seg = in_pg && cfg.seg_src.en && (pg_f == cfg.seg_src.idx);
        lvl_route[0] = cfg.blk[blk_f];
        lvl_route[1] = cfg.pg[pg_f];
        lvl_route[2] = cfg.seg[seg_f];
        lvl_act[0] = addr_valid && !in_pg;
        lvl_act[1] = addr_valid && in_pg && !in_seg;
        lvl_act[2] = addr_valid && in_seg;
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        amd_route_dec #(.NUM_MAP(NUM_MAP)) u_dec (
            .r      (lvl_route[l]),
            .active (lvl_act[l]),
            .hit    (lvl_hit[l])
        );
    end

    always_comb begin
        any_hit = '0;
        for (int l = 0; l < LEVELS; l++) any_hit |= lvl_hit[l];
    end

    assign map_n = ~any_hit;

    // R9: never two selects at once
    a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~map_n));
    // R2: idle bus drives nothing
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> &map_n);
    // R7: disabled coarse entry outside nominated block drives nothing
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !(cfg.pg_src.en && addr[BLK_LSB +: SEL_W] == cfg.pg_src.idx)
        && !cfg.blk[addr[BLK_LSB +: SEL_W]].en |-> &map_n);
    // R3: enabled coarse entry pulls its line low
    a_r3_block_select: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !(cfg.pg_src.en && addr[BLK_LSB +: SEL_W] == cfg.pg_src.idx)
        && cfg.blk[addr[BLK_LSB +: SEL_W]].en
        && (int'(cfg.blk[addr[BLK_LSB +: SEL_W]].idx) < NUM_MAP)
        |-> !map_n[cfg.blk[addr[BLK_LSB +: SEL_W]].idx]);
endmodule

// File: tb/sim_addr_map_decoder.sv
module sim_addr_map_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] addr = '0;
    logic        addr_valid = 0;
    logic        cfg_we = 0;
    logic [5:0]  cfg_addr = '0;
    logic [4:0]  cfg_wdata = '0;
    logic [13:0] map_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [4:0] m_blk [16];
    logic [4:0] m_pg  [16];
    logic [4:0] m_seg [16];
    logic [4:0] m_psrc, m_ssrc;

    // address, expected map_n after the example mapping (R3..R7)
    localparam logic [29:0] VEC [NVEC] = '{
        {16'h6123, 14'h3FFB}, {16'hA000, 14'h3FBF}, {16'hDFFF, 14'h3FBF},
        {16'hE000, 14'h3FFF}, {16'h9FFF, 14'h3FFF}, {16'h7500, 14'h3FEF},
        {16'h7000, 14'h3FFF}, {16'h7305, 14'h3FFE}, {16'h7318, 14'h3FFD},
        {16'h7320, 14'h3FFF}, {16'h0000, 14'h1FFF}, {16'h1234, 14'h3FFF},
        {16'h2000, 14'h3FFF}, {16'hB7C4, 14'h3FBF}
    };

    addr_map_decoder u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .addr_valid(addr_valid),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .map_n(map_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [13:0] ref_map(input logic [15:0] a, input logic v);
        logic [4:0] e;
        logic [13:0] r;
        r = '1;
        if (m_psrc[4] && a[15:12] == m_psrc[3:0]) begin
            if (m_ssrc[4] && a[11:8] == m_ssrc[3:0]) e = m_seg[a[7:4]];
            else e = m_pg[a[11:8]];
        end else e = m_blk[a[15:12]];
        if (v && e[4] && e[3:0] < 4'd14) r[e[3:0]] = 1'b0;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] a, input logic [13:0] exp);
        addr = a;
        #1;
        checks++;
        if (map_n !== exp) begin
            fails++;
            $display("FAIL %s addr=%h map_n=%h expected=%h", tag, a, map_n, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [4:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        case (a[5:4])
            2'd0: m_blk[a[3:0]] = d;
            2'd1: m_pg[a[3:0]]  = d;
            2'd2: m_seg[a[3:0]] = d;
            default: if (a[0]) m_ssrc = d; else m_psrc = d;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_blk[i] = '0; m_pg[i] = '0; m_seg[i] = '0; end
        m_psrc = '0; m_ssrc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        addr_valid = 1;
        // R1: all lines high after reset
        chk("R1", 16'h0000, 14'h3FFF);
        chk("R1", 16'h7305, 14'h3FFF);
        chk("R1", 16'hFFFF, 14'h3FFF);

        // example mapping
        wr(6'h06, 5'h12);                         // block 6 -> line 2
        for (int b = 10; b <= 13; b++) wr(6'(b), 5'h16); // R4: A..D -> line 6
        wr(6'h07, 5'h19);                         // block 7 entry (masked)
        wr(6'h00, 5'h1D);                         // block 0 -> line 13
        wr(6'h01, 5'h1E);                         // R7: index 14
        wr(6'h02, 5'h05);                         // R7: disabled
        wr(6'h30, 5'h17);                         // page source block 7
        wr(6'h15, 5'h14);                         // page 5 -> line 4
        wr(6'h13, 5'h1A);                         // page 3 entry (masked)
        wr(6'h31, 5'h13);                         // segment source page 3
        wr(6'h20, 5'h10);                         // seg 0 -> line 0
        wr(6'h21, 5'h11);                         // seg 1 -> line 1

        for (int i = 0; i < NVEC; i++)
            chk($sformatf("R3/R4/R5/R6/R7 vec%0d", i), VEC[i][29:14], VEC[i][13:0]);

        // R2: valid low hides everything
        addr_valid = 0;
        chk("R2", 16'h6000, 14'h3FFF);
        chk("R2", 16'h7305, 14'h3FFF);
        addr_valid = 1;

        // R8: write not visible before the edge, visible after
        @(negedge clk);
        addr = 16'h6000;
        cfg_we = 1; cfg_addr = 6'h06; cfg_wdata = 5'h13;
        #1; checks++;
        if (map_n !== 14'h3FFB) begin fails++; $display("FAIL R8 early map_n=%h expected=3ffb", map_n); end
        @(negedge clk);
        cfg_we = 0; m_blk[6] = 5'h13;
        chk("R8", 16'h6000, 14'h3FF7);

        // R10: page source off returns block 7 to its own entry
        wr(6'h30, 5'h07);
        chk("R10", 16'h7500, 14'h3DFF);
        wr(6'h30, 5'h17);
        // R6: segment source off -> page 3 entry decides
        wr(6'h31, 5'h03);
        chk("R6", 16'h7305, 14'h3BFF);
        wr(6'h31, 5'h13);

        // R9 and full sweep against model
        for (int a = 0; a < 65536; a++) begin
            addr = 16'(a);
            #1;
            checks++;
            if (map_n !== ref_map(16'(a), 1'b1)) begin
                fails++;
                $display("FAIL R9 sweep addr=%h map_n=%h expected=%h", a, map_n, ref_map(16'(a), 1'b1));
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule